// File: doc/BRIEF.md
# BCH8 Sector Bit Corrector

This block finishes the correction of one 512-byte sector after an 8-error BCH decoder has located the flipped bits. The decoder hands over an error count and eight packed 13-bit bit positions. These are spread over three 32-bit location words and one byte of a status word. The block unpacks the positions and adjusts each one by XOR with 3. It drops any position that lands outside the 4096 data bits, which covers positions that point into the parity bytes. For each remaining position it flips the addressed bit in a sector buffer, using a read-modify-write on a single-port byte RAM.

A controller pulses the start input once the decoder's status word shows its result is ready. The block then runs on its own. When it finishes it raises a one-cycle done pulse and holds two results. One is the number of bits it actually flipped. The other is a flag marking the sector as uncorrectable when the reported count was beyond the code's strength.

Top module: `bch8_bitfix`

## Requirements
- R1: After reset, busy_o, done_o, uncorr_o and fixed_cnt_o are 0, and the RAM read and write strobes stay low whenever busy_o is low.
- R2: A start_i pulse is taken only while the block is idle and status_i bit 15 (result ready) is 1. Otherwise it has no effect: busy_o stays 0 and the RAM is not touched.
- R3: The error count is status_i[13:10], sampled at start. A count of 0 finishes with done_o, fixed_cnt_o = 0, uncorr_o = 0 and no RAM access.
- R4: A count above 8 finishes with done_o, uncorr_o = 1, fixed_cnt_o = 0 and no RAM access.
- R5: Raw position k (k = 0..7) is bits [13k+12:13k] of the 104-bit value {status_i[23:16], word3_i, word2_i, word1_i}. Only positions 0 to count-1 are used, in ascending k order.
- R6: Each used raw position is XORed with 3. The result selects byte address pos>>3 and bit pos&7 (bit 0 is the byte's LSB).
- R7: An adjusted position of 4096 or more is skipped with no RAM access and is not counted.
- R8: Each applied position reads its byte, then writes it back one cycle later to the same address with the selected bit inverted. The RAM has one cycle of read latency, and read and write never assert together.
- R9: fixed_cnt_o equals the number of positions applied. done_o is a single-cycle pulse after the last write. busy_o is high from the cycle after start up to and including the done cycle. Results hold until the next start.
- R10: The location words and the status word are captured at start. Changes to them while busy have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| status_i | input | 32 | Decoder status: ready bit 15, count 13:10, top location byte 23:16 |
| word1_i | input | 32 | Packed location bits 31:0 |
| word2_i | input | 32 | Packed location bits 63:32 |
| word3_i | input | 32 | Packed location bits 95:64 |
| ram_addr_o | output | 9 | Sector buffer byte address |
| ram_rd_o | output | 1 | RAM read strobe (data returns next cycle) |
| ram_rdata_i | input | 8 | RAM read data |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fixed_cnt_o | output | 4 | Number of bits flipped |
| uncorr_o | output | 1 | Sector uncorrectable |

## Verification
The main function is exercised with eight in-range positions that straddle every word boundary, and with a count of three whose second position falls beyond the data area while a later unused slot is valid. These two cases separate correct unpacking and filtering from slicing errors and from off-by-one loops. A repeated position shows that each bit flip is a real read-modify-write, because the byte must return to its old value. Raw values 4092, 4093, 4095 and 4096 probe the XOR-with-3 step at the edge of the data area. Counts of 0, 9 and 15, a start with the ready bit clear, and a run whose inputs change in flight cover the paths that must not touch the RAM.

// File: rtl/bch8_fix_pkg.sv
package bch8_fix_pkg;
  // Location format fixed by the decoder: eight 13-bit positions
  localparam int LOC_W  = 13;
  localparam int N_LOC  = 8;
  localparam int PACK_W = LOC_W * N_LOC;

  // Decoder reports positions offset by 3 in the two low bits
  function automatic logic [LOC_W-1:0] loc_adjust(input logic [LOC_W-1:0] raw);
    return raw ^ LOC_W'(3);
  endfunction

  function automatic logic loc_in_data(input logic [LOC_W-1:0] pos, input int data_bits);
    return int'(pos) < data_bits;
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] bsel);
    return 8'(1) << bsel;
  endfunction
endpackage

// File: rtl/bch8_loc_unpack.sv
module bch8_loc_unpack
  import bch8_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [PACK_W-1:0]           packed_i,
  output logic [N_LOC-1:0][LOC_W-1:0] pos_o,
  output logic [N_LOC-1:0]            ok_o
);
  localparam int DATA_BITS = SECTOR_BYTES * 8;

  for (genvar k = 0; k < N_LOC; k++) begin : g_slot
    logic [LOC_W-1:0] raw_k;
    assign raw_k    = packed_i[k*LOC_W +: LOC_W];
    assign pos_o[k] = loc_adjust(raw_k);
    assign ok_o[k]  = loc_in_data(pos_o[k], DATA_BITS);
  end
endmodule

// File: rtl/bch8_fix_seq.sv
module bch8_fix_seq
  import bch8_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 4,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int SEL_W       = $clog2(N_LOC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_LOC-1:0][LOC_W-1:0] pos_i,
  input  logic [N_LOC-1:0]           ok_i,
  output logic [ADDR_W-1:0]          ram_addr_o,
  output logic                       ram_rd_o,
  input  logic [7:0]                 ram_rdata_i,
  output logic                       ram_wr_o,
  output logic [7:0]                 ram_wdata_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [CNT_W-1:0]           fixed_o,
  output logic                       uncorr_o
);
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_WR, S_FIN} state_t;

  state_t           state_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [SEL_W-1:0] sel;
  logic [LOC_W-1:0] cur_pos;
  logic             cur_ok, at_end, too_many;

  assign sel      = idx_q[SEL_W-1:0];
  assign cur_pos  = pos_i[sel];
  assign cur_ok   = ok_i[sel];
  assign at_end   = (idx_q == cnt_q);
  assign too_many = (cnt_i > CNT_W'(N_LOC));

  assign ram_addr_o  = cur_pos[ADDR_W+2:3];
  assign ram_rd_o    = (state_q == S_PICK) && !at_end && cur_ok;
  assign ram_wr_o    = (state_q == S_WR);
  assign ram_wdata_o = ram_rdata_i ^ bit_mask(cur_pos[2:0]);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      fixed_o  <= '0;
      uncorr_o <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (go_i) begin
          cnt_q    <= cnt_i;
          idx_q    <= '0;
          fixed_o  <= '0;
          uncorr_o <= too_many;
          state_q  <= too_many ? S_FIN : S_PICK;
        end
        S_PICK: begin
          if (at_end)      state_q <= S_FIN;
          else if (cur_ok) state_q <= S_WR;
          else             idx_q   <= idx_q + 1'b1;
        end
        S_WR: begin
          fixed_o <= fixed_o + 1'b1;
          idx_q   <= idx_q + 1'b1;
          state_q <= S_PICK;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_wr_follows_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_o |-> $past(ram_rd_o));
  p_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_o |-> ram_addr_o == $past(ram_addr_o));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_uncorr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && uncorr_o) |-> fixed_o == '0);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(ram_rd_o || ram_wr_o));
  p_fix_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !uncorr_o) |-> fixed_o <= cnt_q);
endmodule

// File: rtl/bch8_bitfix.sv
module bch8_bitfix
  import bch8_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int WORD_W       = 32,
  parameter int CNT_W        = 4,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] word1_i,
  input  logic [WORD_W-1:0] word2_i,
  input  logic [WORD_W-1:0] word3_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_rd_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              ram_wr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fixed_cnt_o,
  output logic              uncorr_o
);
  // Status word fields consumed by this block
  localparam int RDY_BIT = 15;
  localparam int CNT_LO  = 10;
  localparam int TOP_LO  = 16;
  localparam int TOP_W   = PACK_W - 3 * WORD_W;

  logic              accept;
  logic [PACK_W-1:0] pack_q, pack_d;
  logic [N_LOC-1:0][LOC_W-1:0] pos;
  logic [N_LOC-1:0]  ok;

  assign accept = start_i && status_i[RDY_BIT] && !busy_o;
  assign pack_d = {status_i[TOP_LO +: TOP_W], word3_i, word2_i, word1_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pack_q <= '0;
    else if (accept) pack_q <= pack_d;
  end

  bch8_loc_unpack #(.SECTOR_BYTES(SECTOR_BYTES)) u_unpack (
    .packed_i (pack_q),
    .pos_o    (pos),
    .ok_o     (ok)
  );

  bch8_fix_seq #(.SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (accept),
    .cnt_i       (status_i[CNT_LO +: CNT_W]),
    .pos_i       (pos),
    .ok_i        (ok),
    .ram_addr_o  (ram_addr_o),
    .ram_rd_o    (ram_rd_o),
    .ram_rdata_i (ram_rdata_i),
    .ram_wr_o    (ram_wr_o),
    .ram_wdata_o (ram_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fixed_o     (fixed_cnt_o),
    .uncorr_o    (uncorr_o)
  );

  p_hold_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(pack_q));
  p_no_rw_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_o && ram_wr_o));
endmodule

// File: tb/bch8_bitfix_bench.sv
`timescale 1ns/1ps
module bch8_bitfix_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] status_i = '0, word1_i = '0, word2_i = '0, word3_i = '0;
  logic [8:0]  ram_addr_o;
  logic        ram_rd_o, ram_wr_o, busy_o, done_o, uncorr_o;
  logic [7:0]  ram_rdata_i, ram_wdata_o;
  logic [3:0]  fixed_cnt_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ram [512];
  logic [7:0] mdl [512];
  int exp_addr [$];
  int exp_data [$];

  always #2 clk = ~clk;

  bch8_bitfix u_bch8_bitfix (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
    .word1_i(word1_i), .word2_i(word2_i), .word3_i(word3_i),
    .ram_addr_o(ram_addr_o), .ram_rd_o(ram_rd_o), .ram_rdata_i(ram_rdata_i),
    .ram_wr_o(ram_wr_o), .ram_wdata_o(ram_wdata_o), .busy_o(busy_o),
    .done_o(done_o), .fixed_cnt_o(fixed_cnt_o), .uncorr_o(uncorr_o)
  );

  // Sector buffer: one-cycle read latency
  always @(posedge clk) begin
    if (ram_rd_o) ram_rdata_i <= ram[ram_addr_o];
    if (ram_wr_o) ram[ram_addr_o] <= ram_wdata_o;
  end

  task automatic fail(input string tag, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) fail(tag, act, exp);
  endtask

  // Per-clock comparison of every write against the reference queue (R8, R6)
  always @(negedge clk) begin
    if (rst_n && ram_rd_o && ram_wr_o) begin
      checks++; fail("R8 read/write overlap", 1, 0);
    end
    if (rst_n && !busy_o && (ram_rd_o || ram_wr_o)) begin
      checks++; fail("R1 strobe while idle", 1, 0);
    end
    if (rst_n && ram_wr_o) begin
      if (exp_addr.size() == 0) begin
        checks++; fail("R7 unexpected write addr", int'(ram_addr_o), -1);
      end else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        check("R6 write address", int'(ram_addr_o), ea);
        check("R8 write data", int'(ram_wdata_o), ed);
      end
    end
  end

  function automatic logic [103:0] pack8(input int l[8]);
    logic [103:0] p = '0;
    for (int k = 0; k < 8; k++) p = p | (104'(l[k] & 8191) << (13 * k));
    return p;
  endfunction

  task automatic run(input int l[8], input int cnt, input bit rdy, input bit disturb,
                     input int exp_fix, input bit exp_unc, input string tag);
    logic [103:0] p;
    int wd;
    p = pack8(l);
    word1_i = p[31:0]; word2_i = p[63:32]; word3_i = p[95:64];
    status_i = '0;
    status_i[23:16] = p[103:96];
    status_i[15] = rdy;
    status_i[13:10] = 4'(cnt);
    if (cnt <= 8 && rdy) begin
      for (int k = 0; k < cnt; k++) begin
        int pos;
        pos = l[k] ^ 3;
        if (pos < 4096) begin
          mdl[pos >> 3] = mdl[pos >> 3] ^ 8'(1 << (pos & 7));
          exp_addr.push_back(pos >> 3);
          exp_data.push_back(int'(mdl[pos >> 3]));
        end
      end
    end
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (disturb) begin
      word1_i = ~word1_i; word2_i = 32'h0; word3_i = 32'h1234_5678;
      status_i = 32'h00FF_BC00;
    end
    if (!rdy) begin
      for (int c = 0; c < 4; c++) begin
        check({tag, " R2 busy stays low"}, int'(busy_o), 0);
        @(negedge clk);
      end
      return;
    end
    check({tag, " R9 busy after start"}, int'(busy_o || done_o), 1);
    wd = 0;
    while (!done_o && wd < 200) begin @(negedge clk); wd++; end
    if (wd >= 200) begin checks++; fail({tag, " watchdog"}, wd, 0); end
    check({tag, " R9 fixed count"}, int'(fixed_cnt_o), exp_fix);
    check({tag, " R4 uncorr flag"}, int'(uncorr_o), int'(exp_unc));
    check({tag, " R5 all writes seen"}, exp_addr.size(), 0);
    exp_addr.delete(); exp_data.delete();
    @(negedge clk);
    check({tag, " R9 done single pulse"}, int'(done_o), 0);
    check({tag, " R9 result held"}, int'(fixed_cnt_o), exp_fix);
    begin
      int bad = 0;
      for (int a = 0; a < 512; a++) if (ram[a] !== mdl[a]) bad++;
      check({tag, " R6 sector contents"}, bad, 0);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int la[8], lb[8], lc[8], ld[8], lh[8];
    for (int a = 0; a < 512; a++) begin
      ram[a] = 8'((a * 37 + 11) & 255);
      mdl[a] = ram[a];
    end
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy_o), 0);
    check("R1 done at reset", int'(done_o), 0);
    check("R1 count at reset", int'(fixed_cnt_o), 0);
    check("R1 uncorr at reset", int'(uncorr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6: eight in-range positions, boundary values at the top of the area
    la = '{0, 1, 100, 2047, 3000, 4092, 17, 4095};
    run(la, 8, 1'b1, 1'b0, 8, 1'b0, "R5 full set");
    // R7: second position lands beyond data; unused slot 3 must not apply
    lb = '{10, 4096, 20, 30, 0, 0, 0, 0};
    run(lb, 3, 1'b1, 1'b0, 2, 1'b0, "R7 skip out of range");
    // R8: same bit twice restores the byte
    lc = '{50, 50, 4093, 0, 0, 0, 0, 0};
    run(lc, 2, 1'b1, 1'b0, 2, 1'b0, "R8 duplicate");
    // R3: count zero
    ld = '{5, 6, 7, 8, 9, 10, 11, 12};
    run(ld, 0, 1'b1, 1'b0, 0, 1'b0, "R3 zero count");
    // R4: counts above eight
    run(ld, 9, 1'b1, 1'b0, 0, 1'b1, "R4 count 9");
    run(ld, 15, 1'b1, 1'b0, 0, 1'b1, "R4 count 15");
    // R2: ready bit clear
    run(ld, 4, 1'b0, 1'b0, 0, 1'b0, "R2 not ready");
    check("R2 result unchanged", int'(uncorr_o), 1);
    // R10: inputs disturbed while busy
    lh = '{200, 4000, 333, 1234, 0, 0, 0, 0};
    run(lh, 4, 1'b1, 1'b1, 4, 1'b0, "R10 disturbed");
    // R7: all positions outside data
    lh = '{8191, 8191, 4099, 5000, 4096, 4100, 6000, 7000};
    run(lh, 8, 1'b1, 1'b0, 0, 1'b0, "R7 none in range");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule